// File: doc/BRIEF.md
# Ethernet PHY Management Register Model with Timed Link Negotiation

This block stands in for an Ethernet PHY as seen from the MAC's management command register. It holds thirty-two 16-bit PHY registers. Each register carries fixed read and write permissions, and the whole array loads fixed values at reset. A command word enters on a valid/ready channel. Exactly one cycle after acceptance, a response word leaves on a second valid/ready channel. The response echoes the command with a completion flag set, an error flag where needed and, for reads, the register contents.

Suppose a command writes the control register with both the negotiation-enable bit and the restart bit set. The link then drops at once, both on the MAC-side link output and in the PHY status register. The negotiation-complete status bit clears, and a counter starts timing a delay (500 ms by default). When the counter expires, the link returns and negotiation-complete is set. The control register's loopback bit is driven out as a plain flag, so the data path can turn transmitted frames back into the local receive path.

Back-pressure rules: `cmd_ready` is high only while no response is waiting. A response stays valid and unchanged until `rsp_ready` is seen high at a clock edge. So at most one command is in flight.

Top module: `phy_mgmt_model`

## Requirements
- R1: During synchronous active-low reset the control register (address 0) loads 0x1140 and the status register (address 1) loads 0x794D. If `ext_link_up` is low during reset, status bit 2 loads 0 (0x7949) and `mac_link_up` is 0; otherwise `mac_link_up` is 1.
- R2: Command word fields: data in bits 15:0, register address in bits 20:16, opcode in bits 27:26 (01 write, 10 read), interrupt request in bit 29. The response echoes the command, except that bit 28 is the ready flag, bit 30 is the error flag, and bits 15:0 carry read data for a read.
- R3: `cmd_ready` is low while a response is pending. The response appears in the cycle after acceptance and holds its value until taken with `rsp_ready`.
- R4: A read returns the current register value. A write to a writable register (0, 4, 9, 16, 20) stores its data.
- R5: A write to a register without write permission leaves that register unchanged and sets error bit 30. A read of a register without read permission returns error bit 30 and data 0. Any opcode other than 01 or 10 returns error bit 30.
- R6: Every response has ready bit 28 set.
- R7: `mgmt_irq` pulses for exactly the first cycle of a response, and only when bit 29 of that command was set.
- R8: A write to register 0 with bits 12 and 9 both set clears `mac_link_up`, status bit 2 and status bit 5, and raises `an_pending`.
- R9: Exactly CLK_HZ*AN_MS/1000 cycles after the restart write is accepted, `mac_link_up`, status bit 2 and status bit 5 are set and `an_pending` falls.
- R10: A register 0 write with only one of bits 12 and 9 set does not disturb the link or start the delay.
- R11: A restart written while a delay is pending begins the full delay again from the new write.
- R12: `loopback_en` follows bit 14 of register 0.
- R13: Reset cancels a pending delay, so no completion follows the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_link_up | input | 1 | Line link state, sampled during reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_word | input | 32 | Management command |
| rsp_valid | output | 1 | Response word available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_word | output | 32 | Management response |
| mgmt_irq | output | 1 | Command-done interrupt pulse |
| mac_link_up | output | 1 | MAC-side link status |
| loopback_en | output | 1 | Data-path loopback select |
| an_pending | output | 1 | Negotiation delay running |

## Verification
The bench builds the block with CLK_HZ = 1000 and AN_MS = 100, which shrinks the negotiation delay to 100 cycles. With that setting the exact expiry cycle, a restart issued halfway through the delay, and a reset that cuts the delay short can all be checked cycle by cycle in a short run. The register file, permission map and command format are the same as at the default parameters, so every access corner is covered as built.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam int NREG   = 1 << ADDR_W;
  localparam int CMD_W  = 32;

  // register addresses
  localparam logic [ADDR_W-1:0] RA_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] RA_STAT  = 5'd1;
  localparam logic [ADDR_W-1:0] RA_ID_HI = 5'd2;
  localparam logic [ADDR_W-1:0] RA_ID_LO = 5'd3;
  localparam logic [ADDR_W-1:0] RA_ADV   = 5'd4;
  localparam logic [ADDR_W-1:0] RA_PEER  = 5'd5;
  localparam logic [ADDR_W-1:0] RA_GCTL  = 5'd9;
  localparam logic [ADDR_W-1:0] RA_GSTA  = 5'd10;
  localparam logic [ADDR_W-1:0] RA_VCTL  = 5'd16;
  localparam logic [ADDR_W-1:0] RA_VSTA  = 5'd17;
  localparam logic [ADDR_W-1:0] RA_VXCTL = 5'd20;

  // control / status bit positions
  localparam int CB_LOOP    = 14;
  localparam int CB_NEG_EN  = 12;
  localparam int CB_NEG_GO  = 9;
  localparam int SB_LINK    = 2;
  localparam int SB_NEG_OK  = 5;

  // command word fields
  localparam int KF_ADDR_LO = 16;
  localparam int KF_OP_LO   = 26;
  localparam int KF_RDY     = 28;
  localparam int KF_IRQ     = 29;
  localparam int KF_ERR     = 30;

  typedef enum logic [1:0] {
    OP_NONE0 = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE3 = 2'b11
  } mgmt_op_e;

  function automatic logic can_read(input logic [ADDR_W-1:0] a);
    case (a)
      RA_CTRL, RA_STAT, RA_ID_HI, RA_ID_LO, RA_ADV, RA_PEER,
      RA_GCTL, RA_GSTA, RA_VCTL, RA_VSTA, RA_VXCTL: can_read = 1'b1;
      default: can_read = 1'b0;
    endcase
  endfunction

  function automatic logic can_write(input logic [ADDR_W-1:0] a);
    case (a)
      RA_CTRL, RA_ADV, RA_GCTL, RA_VCTL, RA_VXCTL: can_write = 1'b1;
      default: can_write = 1'b0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] boot_value(input logic [ADDR_W-1:0] a);
    case (a)
      RA_CTRL:  boot_value = 16'h1140;
      RA_STAT:  boot_value = 16'h794D;
      RA_ID_HI: boot_value = 16'h0141;
      RA_ID_LO: boot_value = 16'h0C20;
      RA_ADV:   boot_value = 16'h0DE1;
      RA_PEER:  boot_value = 16'h01E0;
      RA_GCTL:  boot_value = 16'h0E00;
      RA_GSTA:  boot_value = 16'h3C00;
      RA_VCTL:  boot_value = 16'h0360;
      RA_VSTA:  boot_value = 16'hAC00;
      RA_VXCTL: boot_value = 16'h0D60;
      default:  boot_value = '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_neg_timer.sv
module phy_neg_timer #(
  parameter longint unsigned TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic busy,
  output logic done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          busy_q;

  assign busy = busy_q;
  // a fresh restart outranks an expiry in the same cycle
  assign done = busy_q && (cnt == '0) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (restart) begin
      busy_q <= 1'b1;
      cnt    <= LOAD;
    end else if (busy_q) begin
      if (cnt == '0) busy_q <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assert_restart_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> busy);
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_restart_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done);
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_link_up,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              link_drop,
  input  logic              link_raise,
  output logic [REG_W-1:0]  ctrl_q,
  output logic              mac_link_up
);
  logic [REG_W-1:0] regs [NREG];
  logic             mac_link_q;

  assign rd_data     = regs[rd_addr];
  assign ctrl_q      = regs[RA_CTRL];
  assign mac_link_up = mac_link_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= boot_value(ADDR_W'(i));
      regs[RA_STAT][SB_LINK] <= ext_link_up;
      mac_link_q             <= ext_link_up;
    end else begin
      if (wr_en) regs[wr_addr] <= wr_data;
      if (link_drop) begin
        regs[RA_STAT][SB_LINK]   <= 1'b0;
        regs[RA_STAT][SB_NEG_OK] <= 1'b0;
        mac_link_q               <= 1'b0;
      end else if (link_raise) begin
        regs[RA_STAT][SB_LINK]   <= 1'b1;
        regs[RA_STAT][SB_NEG_OK] <= 1'b1;
        mac_link_q               <= 1'b1;
      end
    end
  end

  assert_ro_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> can_write(wr_addr));
  assert_link_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mac_link_q == regs[RA_STAT][SB_LINK]);
  assert_rise_by_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_link_q) |-> $past(link_raise));
endmodule

// File: rtl/phy_cmd_engine.sv
module phy_cmd_engine
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CMD_W-1:0]  rsp_word,
  output logic              irq,
  output logic [ADDR_W-1:0] rf_addr,
  input  logic [REG_W-1:0]  rf_rdata,
  output logic              rf_wen,
  output logic [REG_W-1:0]  rf_wdata,
  output logic              neg_restart
);
  logic             rsp_valid_q, irq_q;
  logic [CMD_W-1:0] rsp_q, rsp_d;
  logic             accept, is_wr, is_rd, wr_ok, rd_ok;
  mgmt_op_e         op;
  logic [REG_W-1:0] data;

  assign op       = mgmt_op_e'(cmd_word[KF_OP_LO +: 2]);
  assign rf_addr  = cmd_word[KF_ADDR_LO +: ADDR_W];
  assign data     = cmd_word[REG_W-1:0];
  assign is_wr    = (op == OP_WRITE);
  assign is_rd    = (op == OP_READ);
  assign wr_ok    = is_wr && can_write(rf_addr);
  assign rd_ok    = is_rd && can_read(rf_addr);

  assign cmd_ready = !rsp_valid_q;
  assign accept    = cmd_valid && !rsp_valid_q;
  assign rf_wen    = accept && wr_ok;
  assign rf_wdata  = data;
  assign neg_restart = rf_wen && (rf_addr == RA_CTRL)
                    && data[CB_NEG_EN] && data[CB_NEG_GO];

  always_comb begin
    rsp_d         = cmd_word;
    rsp_d[KF_RDY] = 1'b1;
    rsp_d[KF_ERR] = !(wr_ok || rd_ok);
    if (is_rd) rsp_d[REG_W-1:0] = rd_ok ? rf_rdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
      irq_q       <= 1'b0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_q       <= rsp_d;
      irq_q       <= cmd_word[KF_IRQ];
    end else begin
      irq_q <= 1'b0;
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_word  = rsp_q;
  assign irq       = irq_q;

  assert_ready_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_word[KF_RDY]);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rsp_valid && rsp_word[KF_IRQ] && $rose(rsp_valid)));
  assert_hold_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word)));
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 250_000_000,
  parameter int unsigned     AN_MS  = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_link_up,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_word,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_word,
  output logic        mgmt_irq,
  output logic        mac_link_up,
  output logic        loopback_en,
  output logic        an_pending
);
  localparam longint unsigned RAW_TICKS = (CLK_HZ * AN_MS) / 1000;
  localparam longint unsigned AN_TICKS  = (RAW_TICKS < 2) ? 2 : RAW_TICKS;

  logic [ADDR_W-1:0] rf_addr;
  logic [REG_W-1:0]  rf_rdata, rf_wdata, ctrl_q;
  logic              rf_wen, neg_restart, neg_done, neg_busy;

  phy_cmd_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_word(rsp_word),
    .irq(mgmt_irq),
    .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_wen(rf_wen),
    .rf_wdata(rf_wdata), .neg_restart(neg_restart)
  );

  phy_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .ext_link_up(ext_link_up),
    .rd_addr(rf_addr), .rd_data(rf_rdata),
    .wr_en(rf_wen), .wr_addr(rf_addr), .wr_data(rf_wdata),
    .link_drop(neg_restart), .link_raise(neg_done),
    .ctrl_q(ctrl_q), .mac_link_up(mac_link_up)
  );

  phy_neg_timer #(.TICKS(AN_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(neg_restart),
    .busy(neg_busy), .done(neg_done)
  );

  assign loopback_en = ctrl_q[CB_LOOP];
  assign an_pending  = neg_busy;

  assert_pending_link_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    an_pending |-> !mac_link_up);
endmodule

// File: tb/phy_mgmt_model_tb.sv
`timescale 1ns/1ps
module phy_mgmt_model_tb;
  localparam int T = 100;  // CLK_HZ 1000 * AN_MS 100 / 1000

  logic clk = 1'b0;
  logic rst_n, ext_link_up, cmd_valid, rsp_ready;
  logic [31:0] cmd_word;
  logic cmd_ready, rsp_valid, mgmt_irq, mac_link_up, loopback_en, an_pending;
  logic [31:0] rsp_word;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic [31:0] w; logic irq; string tag; } exp_t;
  exp_t sb[$];
  bit seen = 0;

  always #2 clk = ~clk;

  phy_mgmt_model #(.CLK_HZ(1000), .AN_MS(100)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_link_up(ext_link_up),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_word(rsp_word),
    .mgmt_irq(mgmt_irq), .mac_link_up(mac_link_up),
    .loopback_en(loopback_en), .an_pending(an_pending)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] a,
                                      input logic [15:0] d, input logic ie);
    return {1'b0, 1'b0, ie, 1'b0, op, 5'd0, a, d};
  endfunction

  localparam logic [31:0] RDY = 32'h1000_0000;
  localparam logic [31:0] ERR = 32'h4000_0000;

  task automatic issue(input logic [31:0] c, input logic [31:0] e, input string tag);
    exp_t x;
    x.w = e; x.irq = c[29]; x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] d, input string tag);
    issue(mk(2'b10, a, 16'h0, 1'b0), mk(2'b10, a, d, 1'b0) | RDY, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic ie, input string tag);
    issue(mk(2'b01, a, d, ie), mk(2'b01, a, d, ie) | RDY, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset(input logic ext);
    @(negedge clk);
    rst_n = 1'b0; ext_link_up = ext;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (rsp_valid && !seen) begin
        seen = 1;
        if (sb.size() != 0)
          chk(mgmt_irq === sb[0].irq, {"R7 irq ", sb[0].tag}, {31'd0, mgmt_irq}, {31'd0, sb[0].irq});
      end else if (mgmt_irq) begin
        chk(1'b0, "R7 stray irq", 32'd1, 32'd0);
      end
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) chk(1'b0, "R3 unexpected response", rsp_word, 32'd0);
        else begin
          exp_t x;
          x = sb.pop_front();
          chk(rsp_word === x.w, x.tag, rsp_word, x.w);
        end
        seen = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_link_up = 1'b1; cmd_valid = 1'b0; cmd_word = '0; rsp_ready = 1'b1;
    do_reset(1'b1);

    // R1 reset state
    chk(mac_link_up === 1'b1, "R1 link after reset", {31'd0, mac_link_up}, 32'd1);
    chk(loopback_en === 1'b0, "R12 loopback after reset", {31'd0, loopback_en}, 32'd0);
    chk(an_pending === 1'b0, "R1 no pending", {31'd0, an_pending}, 32'd0);
    chk(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R3 idle handshake", {30'd0, cmd_ready, rsp_valid}, 32'd2);
    rd(5'd0, 16'h1140, "R1 ctrl boot");
    rd(5'd1, 16'h794D, "R1 status boot");
    rd(5'd2, 16'h0141, "R4 id read");
    drain();

    // R3 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(5'd0, 16'h1140, "R3 held response");
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b1, "R3 response held", {31'd0, rsp_valid}, 32'd1);
    chk(cmd_ready === 1'b0, "R3 no accept while pending", {31'd0, cmd_ready}, 32'd0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();

    // R4 R7 write with interrupt, read back
    wr(5'd4, 16'h05E1, 1'b1, "R4 R6 write adv");
    rd(5'd4, 16'h05E1, "R4 adv readback");
    // R5 protection and errors
    issue(mk(2'b01, 5'd1, 16'h1234, 1'b1), mk(2'b01, 5'd1, 16'h1234, 1'b1) | RDY | ERR, "R5 write ro");
    rd(5'd1, 16'h794D, "R5 status untouched");
    issue(mk(2'b10, 5'd7, 16'h0, 1'b0), mk(2'b10, 5'd7, 16'h0, 1'b0) | RDY | ERR, "R5 read unimpl");
    issue(mk(2'b11, 5'd0, 16'h5555, 1'b0), mk(2'b11, 5'd0, 16'h5555, 1'b0) | RDY | ERR, "R5 R2 bad opcode");
    rd(5'd0, 16'h1140, "R5 ctrl untouched by bad op");
    drain();

    // R12 loopback
    wr(5'd0, 16'h5140, 1'b0, "R12 set loop");
    drain();
    chk(loopback_en === 1'b1, "R12 loop on", {31'd0, loopback_en}, 32'd1);
    wr(5'd0, 16'h1140, 1'b0, "R12 clear loop");
    drain();
    chk(loopback_en === 1'b0, "R12 loop off", {31'd0, loopback_en}, 32'd0);

    // R10 partial restart bits
    wr(5'd0, 16'h0340, 1'b0, "R10 go only");
    chk(mac_link_up === 1'b1 && an_pending === 1'b0, "R10 go only no drop", {30'd0, mac_link_up, an_pending}, 32'd2);
    wr(5'd0, 16'h1040, 1'b0, "R10 enable only");
    chk(mac_link_up === 1'b1 && an_pending === 1'b0, "R10 enable only no drop", {30'd0, mac_link_up, an_pending}, 32'd2);
    wr(5'd0, 16'h1140, 1'b0, "R10 restore");
    drain();

    // R8 R9 timed negotiation
    wr(5'd0, 16'h1340, 1'b0, "R8 restart write");
    chk(mac_link_up === 1'b0, "R8 link drops", {31'd0, mac_link_up}, 32'd0);
    chk(an_pending === 1'b1, "R8 pending", {31'd0, an_pending}, 32'd1);
    repeat (T-1) @(negedge clk);
    chk(mac_link_up === 1'b0, "R9 still down before expiry", {31'd0, mac_link_up}, 32'd0);
    @(negedge clk);
    chk(mac_link_up === 1'b1, "R9 up at expiry", {31'd0, mac_link_up}, 32'd1);
    chk(an_pending === 1'b0, "R9 pending clears", {31'd0, an_pending}, 32'd0);
    drain();
    rd(5'd1, 16'h796D, "R9 status complete");
    wr(5'd0, 16'h1340, 1'b0, "R8 restart again");
    rd(5'd1, 16'h7949, "R8 status during delay");
    repeat (T+5) @(negedge clk);
    rd(5'd1, 16'h796D, "R9 status after second delay");
    drain();

    // R11 restart mid-delay
    wr(5'd0, 16'h1340, 1'b0, "R11 first restart");
    repeat (50) @(negedge clk);
    wr(5'd0, 16'h1340, 1'b0, "R11 second restart");
    repeat (T-1) @(negedge clk);
    chk(mac_link_up === 1'b0, "R11 full delay restarted", {31'd0, mac_link_up}, 32'd0);
    @(negedge clk);
    chk(mac_link_up === 1'b1, "R11 up after full delay", {31'd0, mac_link_up}, 32'd1);
    drain();

    // R13 reset cancels delay
    wr(5'd0, 16'h1340, 1'b0, "R13 restart before reset");
    repeat (10) @(negedge clk);
    drain();
    do_reset(1'b1);
    chk(mac_link_up === 1'b1 && an_pending === 1'b0, "R13 reset clears pending", {30'd0, mac_link_up, an_pending}, 32'd2);
    repeat (T+10) @(negedge clk);
    rd(5'd1, 16'h794D, "R13 no late completion");
    drain();

    // R1 link down at reset
    do_reset(1'b0);
    chk(mac_link_up === 1'b0, "R1 link down at reset", {31'd0, mac_link_up}, 32'd0);
    rd(5'd1, 16'h7949, "R1 status link down");
    wr(5'd0, 16'h1340, 1'b0, "R9 restart from down");
    repeat (T+5) @(negedge clk);
    chk(mac_link_up === 1'b1, "R9 link comes up", {31'd0, mac_link_up}, 32'd1);
    rd(5'd1, 16'h796D, "R9 status up");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule